// File: doc/BRIEF.md
# Hierarchical Reference-Counted Power Domain Manager

This block tracks which of seven internal power domains in a display controller are in use. Consumers send one request per cycle. Each request is a get or a put, tagged with a one-hot domain identifier. The consumers are four large cluster windows, four small windows that share one domain, and two compression engines. The block keeps a saturating reference count for each domain. It turns the first reference into a power-on strobe and the last release into a power-off strobe, and the per-domain gate units consume those strobes.

The three upper cluster domains sit under the first cluster domain. A reference on a child also holds a reference on the parent. On a get, the parent is taken one cycle before the child, so the parent always powers up first. On a put, the child is released one cycle before the parent. While this second step is pending, the block raises `busy` and drops any new request. When `delayMode` is high, a release that reaches zero loads a per-domain countdown timer instead of switching the domain off at once. A get that arrives while the timer runs cancels the power-off. When the manager leaves reset, it commands every domain on once.

Top module: `pd_refcount_mgr`

## Requirements
- R1: In the first cycle after reset is released, `busy` is high. The first clock edge then drives `onReq` high on all seven bits for one cycle and sets all of `domOn`, with every count at zero.
- R2: A get on bit 1, 2 or 3 (cluster 1 to 3) adds a reference to bit 0 (cluster 0) first, and adds the child reference on the next edge. If both were off, the parent's `onReq` appears exactly one cycle before the child's. `busy` is high for the one cycle between the two steps.
- R3: A get on a domain whose count is zero and whose `domOn` is low produces a one-cycle `onReq` in the cycle after the request is taken, and sets `domOn`. A get on a domain that is already on raises no request.
- R4: With `delayMode` low, a put that brings a count from one to zero produces a one-cycle `offReq` in the cycle after it is taken, and clears `domOn`. Puts that leave the count above zero raise nothing.
- R5: A put on bit 1, 2 or 3 releases the child first and releases bit 0 on the following edge. If both reach zero, the child's `offReq` comes one cycle before the parent's.
- R6: With `delayMode` high, a put that reaches zero leaves `domOn` set and raises `offReq` exactly OFF_DELAY cycles after the edge that took the put, provided the count is still zero at that point.
- R7: A get taken while a domain's delay timer runs cancels the timer. No `onReq` and no later `offReq` result from that delay.
- R8: Bit n of `reqId` selects domain n, in this order: bit 0 cluster 0, bit 1 cluster 1, bit 2 cluster 2, bit 3 cluster 3, bit 4 small windows, bit 5 8K compressor, bit 6 4K compressor. A `reqId` of zero, or one with more than one bit set, is ignored.
- R9: A put on a domain whose count is zero is ignored and sets the sticky `underflowErr`.
- R10: Counts saturate at MAX_REFS (15). A get is rejected as a whole if the target or its parent is full, and it sets the sticky `overflowErr`.
- R11: A request presented while `busy` is high is dropped with no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| delayMode | input | 1 | 1: a release that reaches zero powers off after OFF_DELAY cycles |
| reqValid | input | 1 | Request strobe, one request per cycle |
| reqGet | input | 1 | 1 = get (take a reference), 0 = put (release one) |
| reqId | input | 7 | One-hot domain selector |
| busy | output | 1 | Init or parent-propagation step in progress; requests dropped |
| onReq | output | 7 | Per-domain one-cycle power-on strobe |
| offReq | output | 7 | Per-domain one-cycle power-off strobe |
| domOn | output | 7 | Per-domain logically-on flag |
| underflowErr | output | 1 | Sticky: a put hit a zero count |
| overflowErr | output | 1 | Sticky: a get hit a full count |

## Verification
Several properties are checked on every cycle. A child's count is never nonzero while its parent's count is zero. A domain never receives an on and an off strobe in the same cycle. An off strobe only leaves a domain at zero and off. An on strobe always leaves `domOn` set. `busy` never lasts two cycles in a row. Both error flags stay set once raised. Other behaviour depends on ordering and timing over several cycles, and only the bench's scenarios can show it: the one-cycle gap between parent and child strobes, the exact OFF_DELAY countdown and its cancellation, saturation at the full count, and requests that are dropped while busy. The bench sweeps every domain through every reference depth and compares the strobe totals against a counting model.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

  localparam int NUM_DOM = 7;

  // Domain index order matters: bit position equals request ID bit.
  localparam int DOM_CL0   = 0;
  localparam int DOM_CL1   = 1;
  localparam int DOM_CL2   = 2;
  localparam int DOM_CL3   = 3;
  localparam int DOM_SMALL = 4;
  localparam int DOM_CMP8K = 5;
  localparam int DOM_CMP4K = 6;

  typedef logic [NUM_DOM-1:0] domVec_t;

  // Control-to-datapath strobes, at most one domain touched per cycle
  typedef struct packed {
    domVec_t incVec;
    domVec_t decVec;
    logic    initAll;
  } pdStrobe_t;

  function automatic int parentIdx(input int d);
    if (d >= DOM_CL1 && d <= DOM_CL3) return DOM_CL0;
    return -1;
  endfunction

  function automatic domVec_t parentMask(input domVec_t id);
    domVec_t m;
    m = '0;
    for (int d = 0; d < NUM_DOM; d++) begin
      if (id[d] && parentIdx(d) >= 0) m[parentIdx(d)] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/pdm_ctrl.sv
module pdm_ctrl
  import pdm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reqValid,
  input  logic      reqGet,
  input  domVec_t   reqId,
  input  domVec_t   zeroVec,
  input  domVec_t   fullVec,
  output pdStrobe_t strobe,
  output logic      busy,
  output logic      underflowErr,
  output logic      overflowErr
);

  logic    initActive;
  domVec_t pendVec;
  logic    pendGet;
  domVec_t pMask;
  logic    idOk, accept, getOk, putOk;
  domVec_t pendVecNxt;
  logic    pendGetNxt;

  assign idOk   = (reqId != '0) && ((reqId & (reqId - domVec_t'(1))) == '0);
  assign busy   = initActive || (pendVec != '0);
  assign accept = reqValid && idOk && !busy;
  assign pMask  = parentMask(reqId);
  assign getOk  = (((reqId | pMask) & fullVec) == '0);
  assign putOk  = ((reqId & zeroVec) == '0);

  always_comb begin
    strobe         = '0;
    strobe.initAll = initActive;
    pendVecNxt     = '0;
    pendGetNxt     = 1'b0;
    if (pendVec != '0) begin
      if (pendGet) strobe.incVec = pendVec;
      else         strobe.decVec = pendVec;
    end else if (accept) begin
      if (reqGet && getOk) begin
        if (pMask != '0) begin
          strobe.incVec = pMask;        // parent first
          pendVecNxt    = reqId;
          pendGetNxt    = 1'b1;
        end else begin
          strobe.incVec = reqId;
        end
      end else if (!reqGet && putOk) begin
        strobe.decVec = reqId;          // child first
        pendVecNxt    = pMask;
        pendGetNxt    = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      initActive   <= 1'b1;
      pendVec      <= '0;
      pendGet      <= 1'b0;
      underflowErr <= 1'b0;
      overflowErr  <= 1'b0;
    end else begin
      initActive <= 1'b0;
      pendVec    <= pendVecNxt;
      pendGet    <= pendGetNxt;
      if (accept && !reqGet && !putOk) underflowErr <= 1'b1;
      if (accept && reqGet && !getOk)  overflowErr  <= 1'b1;
    end
  end

  // R11: propagation step lasts exactly one cycle
  p_busy_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  // R9: sticky underflow
  p_udf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    underflowErr |=> underflowErr);
  // R10: sticky overflow
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overflowErr |=> overflowErr);

endmodule

// File: rtl/pdm_datapath.sv
module pdm_datapath
  import pdm_pkg::*;
#(
  parameter int MAX_REFS  = 15,
  parameter int OFF_DELAY = 250_000_000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      delayMode,
  input  pdStrobe_t strobe,
  output domVec_t   zeroVec,
  output domVec_t   fullVec,
  output domVec_t   onReq,
  output domVec_t   offReq,
  output domVec_t   domOn
);

  localparam int CNT_W = $clog2(MAX_REFS + 1);
  localparam int TMR_W = $clog2(OFF_DELAY + 1);

  logic [CNT_W-1:0] cnt [NUM_DOM];

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
    logic [CNT_W-1:0] cntQ;
    logic [TMR_W-1:0] tmr;
    logic             run, onQ, onR, offR;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cntQ <= '0;
        tmr  <= '0;
        run  <= 1'b0;
        onQ  <= 1'b0;
        onR  <= 1'b0;
        offR <= 1'b0;
      end else begin
        onR  <= 1'b0;
        offR <= 1'b0;
        if (strobe.initAll) begin
          onR <= 1'b1;
          onQ <= 1'b1;
        end else if (strobe.incVec[g]) begin
          cntQ <= cntQ + CNT_W'(1);
          if (cntQ == '0) begin
            run <= 1'b0;                  // cancel pending delayed off
            if (!onQ) begin
              onR <= 1'b1;
              onQ <= 1'b1;
            end
          end
        end else if (strobe.decVec[g]) begin
          cntQ <= cntQ - CNT_W'(1);
          if (cntQ == CNT_W'(1)) begin
            if (delayMode) begin
              run <= 1'b1;
              tmr <= TMR_W'(OFF_DELAY);
            end else begin
              offR <= 1'b1;
              onQ  <= 1'b0;
            end
          end
        end else if (run) begin
          if (tmr == TMR_W'(1)) begin
            run <= 1'b0;
            if (cntQ == '0) begin
              offR <= 1'b1;
              onQ  <= 1'b0;
            end
          end else begin
            tmr <= tmr - TMR_W'(1);
          end
        end
      end
    end

    assign cnt[g]     = cntQ;
    assign zeroVec[g] = (cntQ == '0);
    assign fullVec[g] = (cntQ == CNT_W'(MAX_REFS));
    assign onReq[g]   = onR;
    assign offReq[g]  = offR;
    assign domOn[g]   = onQ;

    // R3: an on strobe always leaves the domain flagged on
    p_on_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      onR |-> onQ);
    // R6: off strobe only for an idle, flagged-off domain
    p_off_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      offR |-> (cntQ == '0) && !onQ);
    // R4: never on and off together
    p_on_off_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(onR && offR));

    if (parentIdx(g) >= 0) begin : g_par
      localparam int P = parentIdx(g);
      // R2: a referenced child always has a referenced parent
      p_parent_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cntQ != '0) |-> (cnt[P] != '0));
    end
  end

endmodule

// File: rtl/pd_refcount_mgr.sv
module pd_refcount_mgr
  import pdm_pkg::*;
#(
  parameter int MAX_REFS  = 15,
  parameter int OFF_DELAY = 250_000_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               delayMode,
  input  logic               reqValid,
  input  logic               reqGet,
  input  logic [NUM_DOM-1:0] reqId,
  output logic               busy,
  output logic [NUM_DOM-1:0] onReq,
  output logic [NUM_DOM-1:0] offReq,
  output logic [NUM_DOM-1:0] domOn,
  output logic               underflowErr,
  output logic               overflowErr
);

  pdStrobe_t strobe;
  domVec_t   zeroVec, fullVec;

  pdm_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .reqValid     (reqValid),
    .reqGet       (reqGet),
    .reqId        (reqId),
    .zeroVec      (zeroVec),
    .fullVec      (fullVec),
    .strobe       (strobe),
    .busy         (busy),
    .underflowErr (underflowErr),
    .overflowErr  (overflowErr)
  );

  pdm_datapath #(
    .MAX_REFS  (MAX_REFS),
    .OFF_DELAY (OFF_DELAY)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .delayMode (delayMode),
    .strobe    (strobe),
    .zeroVec   (zeroVec),
    .fullVec   (fullVec),
    .onReq     (onReq),
    .offReq    (offReq),
    .domOn     (domOn)
  );

endmodule

// File: tb/pd_refcount_mgr_tb.sv
`timescale 1ns/1ps
module pd_refcount_mgr_tb;

  localparam int ND   = 7;
  localparam int MAXR = 15;
  localparam int DLY  = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          delayMode = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqGet = 1'b0;
  logic [ND-1:0] reqId = '0;
  logic          busy, underflowErr, overflowErr;
  logic [ND-1:0] onReq, offReq, domOn;

  pd_refcount_mgr #(.MAX_REFS(MAXR), .OFF_DELAY(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .delayMode(delayMode), .reqValid(reqValid),
    .reqGet(reqGet), .reqId(reqId), .busy(busy), .onReq(onReq),
    .offReq(offReq), .domOn(domOn), .underflowErr(underflowErr),
    .overflowErr(overflowErr));

  always #5 clk = ~clk;

  int  checks = 0;
  int  errors = 0;
  int  onSeen [ND];
  int  offSeen[ND];
  time onTime [ND];
  time offTime[ND];
  time tAcc;
  logic busySeen;

  // model state
  int refs[ND];
  bit onM[ND];
  bit pendOff[ND];
  int expOn[ND];
  int expOff[ND];
  bit udfM, ovfM;

  initial begin
    for (int i = 0; i < ND; i++) begin
      onSeen[i] = 0; offSeen[i] = 0; onTime[i] = 0; offTime[i] = 0;
      refs[i] = 0; onM[i] = 0; pendOff[i] = 0; expOn[i] = 0; expOff[i] = 0;
    end
    udfM = 0; ovfM = 0;
  end

  always @(negedge clk) begin
    for (int i = 0; i < ND; i++) begin
      if (onReq[i])  begin onSeen[i]++;  onTime[i]  = $time; end
      if (offReq[i]) begin offSeen[i]++; offTime[i] = $time; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  task automatic incM(input int d);
    if (refs[d] == 0) begin
      pendOff[d] = 0;
      if (!onM[d]) begin expOn[d]++; onM[d] = 1; end
    end
    refs[d]++;
  endtask

  task automatic decM(input int d);
    refs[d]--;
    if (refs[d] == 0) begin
      if (delayMode) pendOff[d] = 1;
      else begin expOff[d]++; onM[d] = 0; end
    end
  endtask

  task automatic expireM();
    for (int i = 0; i < ND; i++)
      if (pendOff[i] && refs[i] == 0) begin
        expOff[i]++; onM[i] = 0; pendOff[i] = 0;
      end
  endtask

  task automatic modelReq(input bit g, input logic [ND-1:0] id);
    int d, p;
    if (id == '0 || $countones(id) != 1) return;   // R8
    d = 0;
    for (int i = 0; i < ND; i++) if (id[i]) d = i;
    p = (d >= 1 && d <= 3) ? 0 : -1;
    if (g) begin
      if (refs[d] == MAXR || (p >= 0 && refs[p] == MAXR)) ovfM = 1;
      else begin
        if (p >= 0) incM(p);
        incM(d);
      end
    end else begin
      if (refs[d] == 0) udfM = 1;
      else begin
        decM(d);
        if (p >= 0) decM(p);
      end
    end
  endtask

  task automatic send(input bit g, input logic [ND-1:0] id);
    @(negedge clk);
    reqValid = 1'b1; reqGet = g; reqId = id;
    @(posedge clk);
    tAcc = $time;
    @(negedge clk);
    busySeen = busy;
    reqValid = 1'b0; reqId = '0;
    @(negedge clk);
    @(negedge clk);
    modelReq(g, id);
  endtask

  task automatic compareAll(input string req);
    for (int i = 0; i < ND; i++) begin
      chk(onSeen[i] == expOn[i], req, $sformatf("onReq count dom%0d", i), onSeen[i], expOn[i]);
      chk(offSeen[i] == expOff[i], req, $sformatf("offReq count dom%0d", i), offSeen[i], expOff[i]);
      chk(domOn[i] == onM[i], req, $sformatf("domOn dom%0d", i), domOn[i], onM[i]);
    end
    chk(underflowErr == udfM, "R9", "underflowErr", underflowErr, udfM);
    chk(overflowErr == ovfM, "R10", "overflowErr", overflowErr, ovfM);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(onReq == '0 && domOn == '0, "R1", "reset outputs", {onReq, domOn}, 0);
    chk(!underflowErr && !overflowErr, "R1", "reset flags", {underflowErr, overflowErr}, 0);
    rst_n = 1'b1;
    #1;
    chk(busy == 1'b1, "R1", "busy before first edge", busy, 1);
    @(negedge clk);
    chk(onReq == 7'h7f, "R1", "init onReq", onReq, 7'h7f);
    chk(domOn == 7'h7f, "R1", "init domOn", domOn, 7'h7f);
    chk(busy == 1'b0, "R1", "busy after init", busy, 0);
    for (int i = 0; i < ND; i++) begin expOn[i] = 1; onM[i] = 1; end
    @(negedge clk);
    chk(onReq == '0, "R1", "init strobe one cycle", onReq, 0);

    // R8: bad IDs ignored, then a put on dom0 must underflow (R9)
    send(1'b1, 7'b0000000);
    send(1'b1, 7'b0000011);
    send(1'b1, 7'b1010000);
    compareAll("R8");
    send(1'b0, 7'b0000001);
    chk(underflowErr == 1'b1, "R9", "put on zero count", underflowErr, 1);
    compareAll("R9");

    // R3/R4/R10 sweep: every domain, every depth, one beyond full
    for (int d = 0; d < ND; d++) begin
      for (int n = 1; n <= MAXR + 1; n++) begin
        for (int k = 0; k < n; k++) send(1'b1, 7'(1 << d));
        compareAll("R3");
        for (int k = 0; k < n; k++) send(1'b0, 7'(1 << d));
        compareAll("R4");
      end
    end
    chk(overflowErr == 1'b1, "R10", "saturation flag", overflowErr, 1);

    // R10: full parent rejects child get entirely
    for (int k = 0; k < MAXR; k++) send(1'b1, 7'b0000001);
    send(1'b1, 7'b0000100);
    compareAll("R10");
    chk(domOn[2] == 1'b0, "R10", "child stays off with full parent", domOn[2], 0);
    for (int k = 0; k < MAXR; k++) send(1'b0, 7'b0000001);
    compareAll("R10");

    // R2: parent on one cycle before child, busy in between
    send(1'b1, 7'b0000100);
    chk(busySeen == 1'b1, "R2", "busy during propagation", busySeen, 1);
    chk(onTime[2] - onTime[0] == 10, "R2", "child on after parent (ns)", onTime[2] - onTime[0], 10);
    chk(onTime[0] - tAcc == 5, "R2", "parent on latency (ns)", onTime[0] - tAcc, 5);
    compareAll("R2");

    // R5: child off one cycle before parent
    send(1'b0, 7'b0000100);
    chk(offTime[0] - offTime[2] == 10, "R5", "parent off after child (ns)", offTime[0] - offTime[2], 10);
    compareAll("R5");

    // R11: request while busy is dropped
    @(negedge clk);
    reqValid = 1'b1; reqGet = 1'b1; reqId = 7'b0000010;
    @(negedge clk);
    reqId = 7'b0010000;
    @(negedge clk);
    reqValid = 1'b0; reqId = '0;
    repeat (2) @(negedge clk);
    modelReq(1'b1, 7'b0000010);
    chk(domOn[4] == 1'b0, "R11", "dropped get left dom4 off", domOn[4], 0);
    compareAll("R11");
    send(1'b0, 7'b0000010);
    compareAll("R11");

    // R6: delayed off timing
    delayMode = 1'b1;
    send(1'b1, 7'b0100000);
    send(1'b0, 7'b0100000);
    repeat (DLY - 4) @(negedge clk);
    chk(domOn[5] == 1'b1, "R6", "still on during delay", domOn[5], 1);
    chk(offSeen[5] == expOff[5], "R6", "no early off", offSeen[5], expOff[5]);
    repeat (6) @(negedge clk);
    expireM();
    chk(offTime[5] - tAcc == longint'(DLY) * 10 + 5, "R6", "delay to off (ns)",
        offTime[5] - tAcc, longint'(DLY) * 10 + 5);
    compareAll("R6");

    // R7: get during timer cancels off
    send(1'b1, 7'b1000000);
    send(1'b0, 7'b1000000);
    repeat (DLY / 2) @(negedge clk);
    send(1'b1, 7'b1000000);
    repeat (2 * DLY) @(negedge clk);
    compareAll("R7");
    chk(domOn[6] == 1'b1, "R7", "still on after cancel", domOn[6], 1);
    send(1'b0, 7'b1000000);
    repeat (DLY + 3) @(negedge clk);
    expireM();
    compareAll("R7");

    // R6 with hierarchy: both timers run out
    send(1'b1, 7'b0001000);
    send(1'b0, 7'b0001000);
    repeat (DLY + 3) @(negedge clk);
    expireM();
    chk(offTime[0] - offTime[3] == 10, "R6", "delayed parent after child (ns)", offTime[0] - offTime[3], 10);
    compareAll("R6");
    delayMode = 1'b0;

    finishRun();
  end

endmodule